// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard control for an in-order pipeline with five stages: fetch, decode with register read, execute, memory access and writeback. It compares the source register numbers of the instructions in decode and execute against the destination register numbers held in the later pipeline registers. From those comparisons it drives the bypass multiplexer select for each of the two ALU operands, and it detects the one case that bypassing cannot cover: an instruction that needs a load's data in the cycle right after the load.

On such a load-use dependence the unit freezes the program counter and the fetch/decode register and tells the execute-stage register to take a bubble. That costs a single cycle. The register file is assumed to write in the first half of a cycle and read in the second. Because of that, a producer three or more slots ahead needs neither a bypass nor a stall. The register file, ALU, memories and pipeline registers are outside this block. The unit only sees their register tags and their write-enable and load flags.

Top module: `hazard_fwd_unit`

## Requirements
- R1: After reset, with no tag matches, both operand selects read 00 (register file) and the three stall outputs are low.
- R2: An operand select reads 10 when the execute/memory register has write enable set, is not a load, has a nonzero destination, and that destination equals the operand's execute-stage source. The value 11 is never produced.
- R3: An operand select reads 01 when the memory/writeback register has write enable set and a nonzero destination equal to the source, and the R2 condition does not hold.
- R4: When both later registers match the same source, the execute/memory register wins and the select reads 10.
- R5: Register 0 never produces a bypass select or a stall, even when every tag is 0 and every enable is set.
- R6: A matching destination whose write enable is low has no effect on the select.
- R7: A load in execute whose nonzero destination equals a used decode-stage source raises pc_hold_o, if_id_hold_o and ex_bubble_o together, in the same cycle.
- R8: A decode-stage source whose used flag is low never causes a stall.
- R9: A stall lasts exactly one cycle. In the cycle right after a stall, no stall is raised, even if the execute inputs still show the load.
- R10: A load two slots ahead of its consumer, so that the load is in memory access while the consumer is in decode, causes no stall.
- R11: A load held in the execute/memory register is never selected as a bypass source (never 10). A match in memory/writeback still gives 01.
- R12: For the sequence load, dependent add, store of the add's result, exactly one stall cycle occurs. The add's first operand gets 01 and the store's data operand gets 10.
- R13: A producer three slots ahead of its consumer causes neither a stall nor a bypass, because the register file already returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | REG_AW | First source tag in decode |
| id_rs1_used_i | input | 1 | Decode instruction reads its first source |
| id_rs2_i | input | REG_AW | Second source tag in decode |
| id_rs2_used_i | input | 1 | Decode instruction reads its second source |
| ex_rs1_i | input | REG_AW | First source tag in execute |
| ex_rs2_i | input | REG_AW | Second source tag in execute |
| ex_rd_i | input | REG_AW | Destination tag in execute |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Destination tag in execute/memory register |
| mem_wen_i | input | 1 | Register write enable in execute/memory register |
| mem_load_i | input | 1 | Execute/memory register holds a load |
| wb_rd_i | input | REG_AW | Destination tag in memory/writeback register |
| wb_wen_i | input | 1 | Register write enable in memory/writeback register |
| fwd_a_o | output | 2 | First operand select: 00 register file, 01 writeback, 10 memory |
| fwd_b_o | output | 2 | Second operand select, same encoding |
| pc_hold_o | output | 1 | Freeze program counter |
| if_id_hold_o | output | 1 | Freeze fetch/decode register |
| ex_bubble_o | output | 1 | Clear control bits entering execute |

## Verification
The bench builds the unit with the default REG_AW of 5, which gives 32 architectural registers. That width makes register 0 and the highest tag, 31, both reachable, so the zero-tag rule and full-width tag compares are checked at their edges. Beside directed port checks, a small model of the tag fields in the pipeline runs short instruction sequences through the unit's stall and bubble outputs. This exercises the one-bubble timing, and the bypass choices of the instructions that follow a stall, in the cycles where they actually arise.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hzd_tag_cmp.sv
module hzd_tag_cmp #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              en_i,
  output logic              hit_o
);
  // register 0 is hardwired; never a dependence
  assign hit_o = en_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output hzd_pkg::fwd_sel_e sel_o
);
  logic mem_hit, wb_hit;

  // a load in EX/MEM has only an address, not data
  hzd_tag_cmp #(.REG_AW(REG_AW)) u_mem_cmp (
    .src_i (src_i),
    .dst_i (mem_rd_i),
    .en_i  (mem_wen_i && !mem_load_i),
    .hit_o (mem_hit)
  );

  hzd_tag_cmp #(.REG_AW(REG_AW)) u_wb_cmp (
    .src_i (src_i),
    .dst_i (wb_rd_i),
    .en_i  (wb_wen_i),
    .hit_o (wb_hit)
  );

  always_comb begin
    if (mem_hit)     sel_o = hzd_pkg::FWD_MEM;
    else if (wb_hit) sel_o = hzd_pkg::FWD_WB;
    else             sel_o = hzd_pkg::FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src_i,
  input  logic [NUM_SRC-1:0]             id_used_i,
  input  logic [REG_AW-1:0]              ex_rd_i,
  input  logic                           ex_load_i,
  output logic                           stall_o
);
  logic [NUM_SRC-1:0] hit;
  logic               stall_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_tag_cmp #(.REG_AW(REG_AW)) u_cmp (
      .src_i (id_src_i[s]),
      .dst_i (ex_rd_i),
      .en_i  (ex_load_i && id_used_i[s]),
      .hit_o (hit[s])
    );
  end

  // after one bubble the load has moved on; never stall twice in a row
  assign stall_o = (|hit) && !stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_o;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic              id_rs1_used_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs2_used_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_hold_o,
  output logic              if_id_hold_o,
  output logic              ex_bubble_o
);
  localparam int unsigned NSRC = hzd_pkg::NUM_SRC;

  logic [NSRC-1:0][REG_AW-1:0] ex_src, id_src;
  logic [NSRC-1:0]             id_used;
  hzd_pkg::fwd_sel_e           sel [NSRC];
  logic                        stall;

  assign ex_src  = {ex_rs2_i, ex_rs1_i};
  assign id_src  = {id_rs2_i, id_rs1_i};
  assign id_used = {id_rs2_used_i, id_rs1_used_i};

  for (genvar s = 0; s < NSRC; s++) begin : g_op
    hzd_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .src_i      (ex_src[s]),
      .mem_rd_i   (mem_rd_i),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .wb_rd_i    (wb_rd_i),
      .wb_wen_i   (wb_wen_i),
      .sel_o      (sel[s])
    );
  end

  hzd_load_use #(.REG_AW(REG_AW), .NUM_SRC(NSRC)) u_lu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_src_i  (id_src),
    .id_used_i (id_used),
    .ex_rd_i   (ex_rd_i),
    .ex_load_i (ex_load_i),
    .stall_o   (stall)
  );

  assign fwd_a_o      = sel[0];
  assign fwd_b_o      = sel[1];
  assign pc_hold_o    = stall;
  assign if_id_hold_o = stall;
  assign ex_bubble_o  = stall;
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] id_rs1_i,
  input logic              id_rs1_used_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic              id_rs2_used_i,
  input logic [REG_AW-1:0] ex_rs1_i,
  input logic [REG_AW-1:0] ex_rs2_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_rd_i,
  input logic              mem_wen_i,
  input logic              mem_load_i,
  input logic [REG_AW-1:0] wb_rd_i,
  input logic              wb_wen_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              pc_hold_o,
  input logic              if_id_hold_o,
  input logic              ex_bubble_o
);
  p_sel_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));

  p_mem_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wen_i && !mem_load_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i)
      |-> fwd_a_o == 2'b10);

  p_zero_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> fwd_a_o == 2'b00);

  p_no_wen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wen_i && !wb_wen_i) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  p_hold_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o == if_id_hold_o) && (pc_hold_o == ex_bubble_o));

  p_stall_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> (ex_load_i && ex_rd_i != '0 &&
                   ((id_rs1_used_i && id_rs1_i == ex_rd_i) ||
                    (id_rs2_used_i && id_rs2_i == ex_rd_i))));

  p_single_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |=> !pc_hold_o);

  p_no_load_mem_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_load_i |-> (fwd_a_o != 2'b10 && fwd_b_o != 2'b10));
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .id_rs1_i      (id_rs1_i),
  .id_rs1_used_i (id_rs1_used_i),
  .id_rs2_i      (id_rs2_i),
  .id_rs2_used_i (id_rs2_used_i),
  .ex_rs1_i      (ex_rs1_i),
  .ex_rs2_i      (ex_rs2_i),
  .ex_rd_i       (ex_rd_i),
  .ex_load_i     (ex_load_i),
  .mem_rd_i      (mem_rd_i),
  .mem_wen_i     (mem_wen_i),
  .mem_load_i    (mem_load_i),
  .wb_rd_i       (wb_rd_i),
  .wb_wen_i      (wb_wen_i),
  .fwd_a_o       (fwd_a_o),
  .fwd_b_o       (fwd_b_o),
  .pc_hold_o     (pc_hold_o),
  .if_id_hold_o  (if_id_hold_o),
  .ex_bubble_o   (ex_bubble_o)
);

// File: tb/hazard_fwd_unit_tb_top.sv
`timescale 1ns/1ps
module hazard_fwd_unit_tb_top;
  localparam int unsigned REG_AW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [REG_AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_u1, id_u2, ex_load, mem_wen, mem_load, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, if_id_hold, ex_bubble;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hazard_fwd_unit #(.REG_AW(REG_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs1_i(id_rs1), .id_rs1_used_i(id_u1),
    .id_rs2_i(id_rs2), .id_rs2_used_i(id_u2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
    .pc_hold_o(pc_hold), .if_id_hold_o(if_id_hold), .ex_bubble_o(ex_bubble)
  );

  typedef struct packed {
    logic              vld;
    logic [3:0]        idx;
    logic [REG_AW-1:0] rd, rs1, rs2;
    logic              u1, u2, ld, wen;
  } ins_t;

  ins_t prog [8];
  logic [1:0] seen_a [8];
  logic [1:0] seen_b [8];
  int stalls;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    id_rs1 = '0; id_rs2 = '0; id_u1 = 0; id_u2 = 0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_load = 0;
    mem_rd = '0; mem_wen = 0; mem_load = 0; wb_rd = '0; wb_wen = 0;
  endtask

  task automatic stall_bits(output logic [2:0] s);
    s = {pc_hold, if_id_hold, ex_bubble};
  endtask

  task automatic t_reset();
    logic [2:0] s;
    clr_in();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    stall_bits(s);
    chk("R1 sel a", {30'd0, fwd_a}, 32'd0);
    chk("R1 sel b", {30'd0, fwd_b}, 32'd0);
    chk("R1 stall", {29'd0, s}, 32'd0);
  endtask

  task automatic t_forward();
    @(negedge clk); clr_in();
    ex_rs1 = 5'd9; ex_rs2 = 5'd31; mem_rd = 5'd9; mem_wen = 1; #1;
    chk("R2 mem sel a", {30'd0, fwd_a}, 32'd2);
    chk("R2 b untouched", {30'd0, fwd_b}, 32'd0);
    @(negedge clk); clr_in();
    ex_rs1 = 5'd4; ex_rs2 = 5'd31; wb_rd = 5'd31; wb_wen = 1; #1;
    chk("R3 wb sel b", {30'd0, fwd_b}, 32'd1);
    chk("R3 a untouched", {30'd0, fwd_a}, 32'd0);
    @(negedge clk); clr_in();
    ex_rs1 = 5'd7; ex_rs2 = 5'd7; mem_rd = 5'd7; mem_wen = 1; wb_rd = 5'd7; wb_wen = 1; #1;
    chk("R4 prio a", {30'd0, fwd_a}, 32'd2);
    chk("R4 prio b", {30'd0, fwd_b}, 32'd2);
    @(negedge clk); clr_in();
    ex_rs1 = 5'd6; mem_rd = 5'd6; wb_rd = 5'd6; #1;
    chk("R6 no wen", {30'd0, fwd_a}, 32'd0);
    @(negedge clk); clr_in();
    mem_wen = 1; wb_wen = 1; ex_load = 1; id_u1 = 1; id_u2 = 1; #1;
    chk("R5 zero fwd a", {30'd0, fwd_a}, 32'd0);
    chk("R5 zero fwd b", {30'd0, fwd_b}, 32'd0);
    chk("R5 zero stall", {31'd0, pc_hold}, 32'd0);
    @(negedge clk); clr_in();
    ex_rs1 = 5'd12; mem_rd = 5'd12; mem_wen = 1; mem_load = 1; #1;
    chk("R11 load no mem", {30'd0, fwd_a}, 32'd0);
    wb_rd = 5'd12; wb_wen = 1; #1;
    chk("R11 falls to wb", {30'd0, fwd_a}, 32'd1);
  endtask

  task automatic t_load_use();
    logic [2:0] s;
    @(negedge clk); clr_in();
    ex_load = 1; ex_rd = 5'd8; id_rs2 = 5'd8; id_u2 = 0; id_rs1 = 5'd3; id_u1 = 1; #1;
    chk("R8 unused src", {31'd0, pc_hold}, 32'd0);
    @(negedge clk);
    id_u2 = 1; #1;
    stall_bits(s);
    chk("R7 all three", {29'd0, s}, 32'd7);
    @(negedge clk); #1;
    stall_bits(s);
    chk("R9 second cycle", {29'd0, s}, 32'd0);
    @(negedge clk); clr_in();
    mem_rd = 5'd8; mem_wen = 1; mem_load = 1; id_rs1 = 5'd8; id_u1 = 1; #1;
    chk("R10 gap no stall", {31'd0, pc_hold}, 32'd0);
  endtask

  task automatic run_prog(input int n, input int cycles);
    ins_t id_r, ex_r, mem_r, wb_r;
    int pc;
    id_r = prog[0]; ex_r = '0; mem_r = '0; wb_r = '0; pc = 1; stalls = 0;
    for (int k = 0; k < 8; k++) begin seen_a[k] = 2'b11; seen_b[k] = 2'b11; end
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      id_rs1 = id_r.rs1; id_rs2 = id_r.rs2; id_u1 = id_r.u1; id_u2 = id_r.u2;
      ex_rs1 = ex_r.rs1; ex_rs2 = ex_r.rs2; ex_rd = ex_r.rd; ex_load = ex_r.ld;
      mem_rd = mem_r.rd; mem_wen = mem_r.wen; mem_load = mem_r.ld;
      wb_rd = wb_r.rd; wb_wen = wb_r.wen;
      #1;
      if (ex_r.vld) begin seen_a[ex_r.idx] = fwd_a; seen_b[ex_r.idx] = fwd_b; end
      wb_r = mem_r; mem_r = ex_r;
      if (pc_hold) begin
        stalls++;
        ex_r = '0;
      end else begin
        ex_r = id_r;
        id_r = (pc < n) ? prog[pc] : '0;
        pc++;
      end
    end
  endtask

  task automatic t_seq_lw_add_sw();
    for (int k = 0; k < 8; k++) prog[k] = '0;
    prog[0] = '{vld:1, idx:0, rd:8,  rs1:7, rs2:0,  u1:1, u2:0, ld:1, wen:1};
    prog[1] = '{vld:1, idx:1, rd:14, rs1:8, rs2:10, u1:1, u2:1, ld:0, wen:1};
    prog[2] = '{vld:1, idx:2, rd:0,  rs1:7, rs2:14, u1:1, u2:1, ld:0, wen:0};
    run_prog(3, 9);
    chk("R12 one stall", stalls, 32'd1);
    chk("R12 add a wb", {30'd0, seen_a[1]}, 32'd1);
    chk("R12 add b rf", {30'd0, seen_b[1]}, 32'd0);
    chk("R12 store data mem", {30'd0, seen_b[2]}, 32'd2);
    chk("R12 store base rf", {30'd0, seen_a[2]}, 32'd0);
  endtask

  task automatic t_distance3();
    for (int k = 0; k < 8; k++) prog[k] = '0;
    prog[0] = '{vld:1, idx:0, rd:1, rs1:2, rs2:3, u1:1, u2:1, ld:1, wen:1};
    prog[1] = '{vld:1, idx:1, rd:0, rs1:0, rs2:0, u1:0, u2:0, ld:0, wen:0};
    prog[2] = '{vld:1, idx:2, rd:0, rs1:0, rs2:0, u1:0, u2:0, ld:0, wen:0};
    prog[3] = '{vld:1, idx:3, rd:4, rs1:1, rs2:1, u1:1, u2:1, ld:0, wen:1};
    run_prog(4, 9);
    chk("R13 no stall", stalls, 32'd0);
    chk("R13 rf a", {30'd0, seen_a[3]}, 32'd0);
    chk("R13 rf b", {30'd0, seen_b[3]}, 32'd0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_forward();
    t_load_use();
    t_seq_lw_add_sw();
    t_distance3();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule